// File: doc/BRIEF.md
# Scan Port Park Controller

This block drives the test-mode-select line of one secondary scan port that hangs below a scan bridge. When the port is live, the outgoing line repeats the backplane test-mode-select (`tmsb`), and the remote TAP controller steps in lockstep with the bridge's own TAP. When the port is parked, the line is pinned to a constant level so that the remote TAP sits still in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. The port then leaves the active scan chain.

The bridge's TAP state and its instruction decode sit outside this block. The bridge state arrives as a 4-bit code. Four one-cycle strobes arrive from the decode: wake, park-in-reset, park-in-idle and park-in-pause. A strobe is asserted during the single cycle in which the bridge TAP is in Update-IR. State changes on the rising edge of `tck`. The outgoing line `tmsl` is relaunched on the falling edge. That gives the remote TAP a full half period of setup before the next rising edge, and the level does not glitch when a park begins or ends. `in_chain` tells the chain multiplexer whether this port's data path belongs in the active chain.

Waking a parked port is deferred. The block waits until the bridge TAP moves into the state in which the remote TAP is being held, and only then does it hand the line back to `tmsb`. Parking in a pause state is also deferred. It takes effect on the Exit1 to Update step, when the bridge leaves a scan with `tmsb` high.

Top module: `scan_port_parker`

## Requirements
- R1: While `trst_n` is low, and after it rises until the first strobe, the port is parked in reset. `tmsl` is 1 and `in_chain` is 0.
- R2: `bridge_state` codes are: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. While the port is live, `tmsl` after each falling edge equals `tmsb` at that edge, and a remote TAP clocked by `tmsl` stays in the bridge's state.
- R3: Park-in-reset on a live port drives `tmsl` to 1 from the falling edge of the strobe cycle onward. `in_chain` drops at the rising edge that ends the strobe cycle, and the remote TAP reaches Test-Logic-Reset within three cycles.
- R4: Park-in-idle on a live port drives `tmsl` to 0 from the falling edge of the strobe cycle onward. `in_chain` drops at the rising edge that ends the strobe cycle, and the remote TAP rests in Run-Test/Idle.
- R5: Park-in-pause on a live port arms it. The port stays in the chain and `tmsl` keeps following `tmsb`, except when the bridge is in Exit1-DR or Exit1-IR with `tmsb` high. In that case `tmsl` is 0, and at that rising edge the port becomes parked in Pause-DR or Pause-IR respectively.
- R6: Wake on a port parked in reset or idle drives `tmsl` to 0 while the wake is pending. The port rejoins the chain at the first rising edge at which the bridge's next state is Run-Test/Idle.
- R7: Wake on a port parked in Pause-DR (Pause-IR) holds `tmsl` at 0. The port rejoins the chain only at a rising edge at which the bridge's next state is Pause-DR (Pause-IR). The other pause state does not release it.
- R8: Park strobes on a parked port, park-in-pause on an armed-or-parked port, and wake on a live port change neither `tmsl` nor `in_chain`. Any park strobe cancels a pending wake and returns the port to its previous park. A port parked in reset returns as parked in idle.
- R9: `in_chain` is 1 exactly while the port is live or armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| bridge_state | input | 4 | Current state code of the bridge TAP (R2) |
| tmsb | input | 1 | Backplane test-mode-select |
| op_wake | input | 1 | One-cycle wake strobe |
| op_park_reset | input | 1 | One-cycle park-in-reset strobe |
| op_park_idle | input | 1 | One-cycle park-in-idle strobe |
| op_park_pause | input | 1 | One-cycle park-in-pause strobe |
| tmsl | output | 1 | Test-mode-select to the secondary port, launched on the falling edge |
| in_chain | output | 1 | Port belongs in the active scan chain |

## Verification
The block has no sizing parameters; its widths are fixed in the package, so the bench builds the single default configuration. Because the bridge TAP has only sixteen states and the controller only seven, a long pseudo-random walk of `tmsb`, with a random strobe in every Update-IR cycle, drives every park kind, every wake and every cancel many times. The bench keeps its own bridge and remote TAP models and checks `tmsl`, `in_chain` and lockstep on every cycle.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int TAP_W  = 4;
  localparam int PARK_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [TAP_W-1:0] {
    T_RESET = 4'd0,  T_IDLE  = 4'd1,  T_SELD  = 4'd2,  T_CAPD  = 4'd3,
    T_SHD   = 4'd4,  T_EX1D  = 4'd5,  T_PAUD  = 4'd6,  T_EX2D  = 4'd7,
    T_UPDD  = 4'd8,  T_SELI  = 4'd9,  T_CAPI  = 4'd10, T_SHI   = 4'd11,
    T_EX1I  = 4'd12, T_PAUI  = 4'd13, T_EX2I  = 4'd14, T_UPDI  = 4'd15
  } tap_state_e;

  typedef enum logic [PARK_W-1:0] {
    PS_LIVE     = 3'd0,
    PS_ARMED    = 3'd1,
    PS_HOLD_TLR = 3'd2,
    PS_HOLD_RTI = 3'd3,
    PS_HOLD_PDR = 3'd4,
    PS_HOLD_PIR = 3'd5,
    PS_WAKE     = 3'd6
  } park_state_e;

  typedef enum logic [KIND_W-1:0] {
    K_IDLE = 2'd0,
    K_PDR  = 2'd1,
    K_PIR  = 2'd2
  } park_kind_e;

  function automatic tap_state_e tap_step(tap_state_e s, logic t);
    tap_state_e n;
    case (s)
      T_RESET: n = t ? T_RESET : T_IDLE;
      T_IDLE:  n = t ? T_SELD  : T_IDLE;
      T_SELD:  n = t ? T_SELI  : T_CAPD;
      T_CAPD:  n = t ? T_EX1D  : T_SHD;
      T_SHD:   n = t ? T_EX1D  : T_SHD;
      T_EX1D:  n = t ? T_UPDD  : T_PAUD;
      T_PAUD:  n = t ? T_EX2D  : T_PAUD;
      T_EX2D:  n = t ? T_UPDD  : T_SHD;
      T_UPDD:  n = t ? T_SELD  : T_IDLE;
      T_SELI:  n = t ? T_RESET : T_CAPI;
      T_CAPI:  n = t ? T_EX1I  : T_SHI;
      T_SHI:   n = t ? T_EX1I  : T_SHI;
      T_EX1I:  n = t ? T_UPDI  : T_PAUI;
      T_PAUI:  n = t ? T_EX2I  : T_PAUI;
      T_EX2I:  n = t ? T_UPDI  : T_SHI;
      default: n = t ? T_SELD  : T_IDLE;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/spp_tap_lookahead.sv
module spp_tap_lookahead
  import spp_pkg::*;
(
  input  logic [TAP_W-1:0] cur,
  input  logic             tms,
  output logic             in_exit1_dr,
  output logic             in_exit1_ir,
  output logic             to_idle,
  output logic             to_pause_dr,
  output logic             to_pause_ir
);
  tap_state_e now_s;
  tap_state_e nxt_s;

  assign now_s = tap_state_e'(cur);
  assign nxt_s = tap_step(now_s, tms);

  assign in_exit1_dr = (now_s == T_EX1D);
  assign in_exit1_ir = (now_s == T_EX1I);
  assign to_idle     = (nxt_s == T_IDLE);
  assign to_pause_dr = (nxt_s == T_PAUD);
  assign to_pause_ir = (nxt_s == T_PAUI);
endmodule

// File: rtl/spp_park_fsm.sv
module spp_park_fsm
  import spp_pkg::*;
(
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tmsb,
  input  logic        op_wake,
  input  logic        op_park_reset,
  input  logic        op_park_idle,
  input  logic        op_park_pause,
  input  logic        in_exit1_dr,
  input  logic        in_exit1_ir,
  input  logic        to_idle,
  input  logic        to_pause_dr,
  input  logic        to_pause_ir,
  output park_state_e st,
  output park_kind_e  kind,
  output logic        force_en,
  output logic        force_val,
  output logic        in_chain
);
  park_state_e st_n;
  park_kind_e  kind_n;
  logic        any_park;
  logic        live;
  logic        exit_hi;
  logic        release_ok;
  park_state_e back_to;

  assign any_park = op_park_reset | op_park_idle | op_park_pause;
  assign live     = (st == PS_LIVE) || (st == PS_ARMED);
  assign exit_hi  = tmsb & (in_exit1_dr | in_exit1_ir);

  always_comb begin
    case (kind)
      K_PDR:   begin release_ok = to_pause_dr; back_to = PS_HOLD_PDR; end
      K_PIR:   begin release_ok = to_pause_ir; back_to = PS_HOLD_PIR; end
      default: begin release_ok = to_idle;     back_to = PS_HOLD_RTI; end
    endcase
  end

  always_comb begin
    st_n   = st;
    kind_n = kind;
    case (st)
      PS_LIVE, PS_ARMED: begin
        if (op_park_reset)                        st_n = PS_HOLD_TLR;
        else if (op_park_idle)                    st_n = PS_HOLD_RTI;
        else if (st == PS_LIVE && op_park_pause)  st_n = PS_ARMED;
        else if (st == PS_ARMED && op_wake)       st_n = PS_LIVE;
        else if (st == PS_ARMED && tmsb && in_exit1_dr) st_n = PS_HOLD_PDR;
        else if (st == PS_ARMED && tmsb && in_exit1_ir) st_n = PS_HOLD_PIR;
      end
      PS_HOLD_TLR, PS_HOLD_RTI: if (op_wake) begin st_n = PS_WAKE; kind_n = K_IDLE; end
      PS_HOLD_PDR:              if (op_wake) begin st_n = PS_WAKE; kind_n = K_PDR;  end
      PS_HOLD_PIR:              if (op_wake) begin st_n = PS_WAKE; kind_n = K_PIR;  end
      PS_WAKE: begin
        if (any_park)        st_n = back_to;
        else if (release_ok) st_n = PS_LIVE;
      end
      default: st_n = PS_HOLD_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st   <= PS_HOLD_TLR;
      kind <= K_IDLE;
    end else begin
      st   <= st_n;
      kind <= kind_n;
    end
  end

  // Level to pin on tmsl for the falling edge of this cycle.
  always_comb begin
    force_en  = 1'b1;
    force_val = 1'b0;
    if (live) begin
      if (op_park_reset)                       force_val = 1'b1;
      else if (op_park_idle)                   force_val = 1'b0;
      else if (st == PS_ARMED && exit_hi)      force_val = 1'b0;
      else                                     force_en  = 1'b0;
    end else if (st == PS_HOLD_TLR) begin
      force_val = 1'b1;
    end
  end

  assign in_chain = live;

  // R5: a pause park is only ever entered from an armed port leaving Exit1 high
  a_r5_pause_from_exit1: assert property (@(posedge tck) disable iff (!trst_n)
    ((st == PS_HOLD_PDR || st == PS_HOLD_PIR) && $past(st) == PS_ARMED)
      |-> ($past(tmsb) && ($past(in_exit1_dr) || $past(in_exit1_ir))));

  // R8: a wake strobe on a live port leaves it in the chain
  a_r8_wake_on_live: assert property (@(posedge tck) disable iff (!trst_n)
    (st == PS_LIVE && op_wake && !any_park) |=> (st == PS_LIVE));
endmodule

// File: rtl/spp_tms_launch.sv
module spp_tms_launch (
  input  logic tck,
  input  logic trst_n,
  input  logic tmsb,
  input  logic force_en,
  input  logic force_val,
  output logic tmsl
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tmsl <= 1'b1;
    else         tmsl <= force_en ? force_val : tmsb;
  end
endmodule

// File: rtl/scan_port_parker.sv
module scan_port_parker
  import spp_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic [TAP_W-1:0] bridge_state,
  input  logic             tmsb,
  input  logic             op_wake,
  input  logic             op_park_reset,
  input  logic             op_park_idle,
  input  logic             op_park_pause,
  output logic             tmsl,
  output logic             in_chain
);
  logic        ex1_dr, ex1_ir, nx_idle, nx_pdr, nx_pir;
  logic        f_en, f_val;
  park_state_e st;
  park_kind_e  kind;

  spp_tap_lookahead u_look (
    .cur(bridge_state), .tms(tmsb),
    .in_exit1_dr(ex1_dr), .in_exit1_ir(ex1_ir),
    .to_idle(nx_idle), .to_pause_dr(nx_pdr), .to_pause_ir(nx_pir)
  );

  spp_park_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tmsb(tmsb),
    .op_wake(op_wake), .op_park_reset(op_park_reset),
    .op_park_idle(op_park_idle), .op_park_pause(op_park_pause),
    .in_exit1_dr(ex1_dr), .in_exit1_ir(ex1_ir),
    .to_idle(nx_idle), .to_pause_dr(nx_pdr), .to_pause_ir(nx_pir),
    .st(st), .kind(kind), .force_en(f_en), .force_val(f_val),
    .in_chain(in_chain)
  );

  spp_tms_launch u_launch (
    .tck(tck), .trst_n(trst_n), .tmsb(tmsb),
    .force_en(f_en), .force_val(f_val), .tmsl(tmsl)
  );

  // R3: a port held in reset for a full cycle presents a high line
  a_r3_reset_hold_high: assert property (@(posedge tck) disable iff (!trst_n)
    (st == PS_HOLD_TLR && $past(st) == PS_HOLD_TLR) |-> tmsl);

  // R6: a pending wake keeps the line low
  a_r6_wake_holds_low: assert property (@(posedge tck) disable iff (!trst_n)
    (st == PS_WAKE && $past(st) == PS_WAKE) |-> !tmsl);

  // R6: release from an idle-kind wake lands with the bridge in Run-Test/Idle
  a_r6_release_in_idle: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(st) == PS_WAKE && $past(kind) == K_IDLE && st == PS_LIVE)
      |-> (bridge_state == T_IDLE));

  // R7: release from a pause-kind wake lands with the bridge in the matching pause
  a_r7_release_in_pause: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(st) == PS_WAKE && $past(kind) != K_IDLE && st == PS_LIVE)
      |-> (bridge_state == (($past(kind) == K_PDR) ? T_PAUD : T_PAUI)));

  // R3: a park-in-reset strobe on a chained port removes it at the next edge
  a_r3_leaves_chain: assert property (@(posedge tck) disable iff (!trst_n)
    (in_chain && op_park_reset) |=> !in_chain);
endmodule

// File: tb/tb_scan_port_parker.sv
module tb_scan_port_parker;
  localparam logic [3:0] S_TLR = 4'd0,  S_RTI = 4'd1,  S_SD = 4'd2,  S_CD = 4'd3;
  localparam logic [3:0] S_HD  = 4'd4,  S_E1D = 4'd5,  S_PD = 4'd6,  S_E2D = 4'd7;
  localparam logic [3:0] S_UD  = 4'd8,  S_SI  = 4'd9,  S_CI = 4'd10, S_HI  = 4'd11;
  localparam logic [3:0] S_E1I = 4'd12, S_PI  = 4'd13, S_E2I = 4'd14, S_UI = 4'd15;
  // bench park modes
  localparam int M_LIVE = 0, M_ARM = 1, M_TLR = 2, M_RTI = 3, M_PDR = 4, M_PIR = 5, M_WAKE = 6;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic       trst_n;
  logic [3:0] bridge_state;
  logic       tmsb, op_wake, op_park_reset, op_park_idle, op_park_pause;
  logic       tmsl, in_chain;

  scan_port_parker dut (
    .tck(tck), .trst_n(trst_n), .bridge_state(bridge_state), .tmsb(tmsb),
    .op_wake(op_wake), .op_park_reset(op_park_reset), .op_park_idle(op_park_idle),
    .op_park_pause(op_park_pause), .tmsl(tmsl), .in_chain(in_chain)
  );

  int total = 0, bad = 0;
  int mode, kind, age;
  logic [3:0] lst;
  logic [31:0] rng = 32'h1234_5678;
  int n_pause_park = 0, n_idle_wake = 0, n_pause_wake = 0, n_cancel = 0, n_ignored = 0;
  bit finished = 0;

  function automatic logic [3:0] tnext(logic [3:0] s, logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SD  : S_RTI;
      S_SD:  return t ? S_SI  : S_CD;
      S_CD:  return t ? S_E1D : S_HD;
      S_HD:  return t ? S_E1D : S_HD;
      S_E1D: return t ? S_UD  : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UD  : S_HD;
      S_UD:  return t ? S_SD  : S_RTI;
      S_SI:  return t ? S_TLR : S_CI;
      S_CI:  return t ? S_E1I : S_HI;
      S_HI:  return t ? S_E1I : S_HI;
      S_E1I: return t ? S_UI  : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UI  : S_HI;
      default: return t ? S_SD : S_RTI;
    endcase
  endfunction

  function automatic logic [31:0] xs(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int m, int k);
    case (m)
      M_LIVE: return "R2";
      M_ARM:  return "R5";
      M_TLR:  return "R3";
      M_RTI:  return "R4";
      M_PDR, M_PIR: return "R5";
      default: return (k == 0) ? "R6" : "R7";
    endcase
  endfunction

  // one bridge cycle: ops = {pause, idle, reset, wake}
  task automatic tick(input logic t, input logic [3:0] ops, input bit do_chk);
    int m0, nm, nk;
    logic exp_t;
    logic [3:0] bn;
    bit park_any;
    string tg;
    tmsb = t;
    op_wake = ops[0]; op_park_reset = ops[1]; op_park_idle = ops[2]; op_park_pause = ops[3];
    m0 = mode;
    park_any = ops[1] | ops[2] | ops[3];
    if (m0 == M_LIVE || m0 == M_ARM) begin
      if (ops[1]) exp_t = 1'b1;
      else if (ops[2]) exp_t = 1'b0;
      else if (m0 == M_ARM && t && (bridge_state == S_E1D || bridge_state == S_E1I)) exp_t = 1'b0;
      else exp_t = t;
    end else exp_t = (m0 == M_TLR);
    tg = ops[1] ? "R3" : ops[2] ? "R4" : tag_of(m0, kind);
    @(negedge tck); #1;
    if (do_chk) chk(tmsl == exp_t, tg, "tmsl level", tmsl, exp_t);
    @(posedge tck); #1;
    bn = tnext(bridge_state, t);
    nm = m0; nk = kind;
    if (!trst_n) nm = M_TLR;
    else case (m0)
      M_LIVE, M_ARM: begin
        if (ops[1]) nm = M_TLR;
        else if (ops[2]) nm = M_RTI;
        else if (m0 == M_LIVE && ops[3]) nm = M_ARM;
        else if (m0 == M_ARM && ops[0]) nm = M_LIVE;
        else if (m0 == M_ARM && t && bridge_state == S_E1D) begin nm = M_PDR; n_pause_park++; end
        else if (m0 == M_ARM && t && bridge_state == S_E1I) begin nm = M_PIR; n_pause_park++; end
        else if (m0 == M_ARM && ops[3]) n_ignored++;
      end
      M_TLR, M_RTI: if (ops[0]) begin nm = M_WAKE; nk = 0; end else if (park_any) n_ignored++;
      M_PDR:        if (ops[0]) begin nm = M_WAKE; nk = 1; end else if (park_any) n_ignored++;
      M_PIR:        if (ops[0]) begin nm = M_WAKE; nk = 2; end else if (park_any) n_ignored++;
      default: begin
        if (park_any) begin nm = (kind == 0) ? M_RTI : (kind == 1) ? M_PDR : M_PIR; n_cancel++; end
        else if ((kind == 0 && bn == S_RTI) || (kind == 1 && bn == S_PD) || (kind == 2 && bn == S_PI)) begin
          nm = M_LIVE;
          if (kind == 0) n_idle_wake++; else n_pause_wake++;
        end
      end
    endcase
    lst = tnext(lst, tmsl);
    bridge_state = bn;
    if (nm == m0) age++; else age = 0;
    mode = nm; kind = nk;
    op_wake = 0; op_park_reset = 0; op_park_idle = 0; op_park_pause = 0;
    if (do_chk) begin
      chk(in_chain == (mode == M_LIVE || mode == M_ARM),
          (park_any && m0 >= M_TLR && m0 != M_WAKE) ? "R8" : "R9",
          "in_chain", in_chain, (mode == M_LIVE || mode == M_ARM));
      case (mode)
        M_LIVE, M_ARM: chk(lst == bridge_state, "R2", "remote lockstep", lst, bridge_state);
        M_TLR: if (age >= 3) chk(lst == S_TLR, "R3", "remote held in reset", lst, S_TLR);
        M_RTI: chk(lst == S_RTI, "R4", "remote held idle", lst, S_RTI);
        M_PDR: chk(lst == S_PD, "R5", "remote held in Pause-DR", lst, S_PD);
        M_PIR: chk(lst == S_PI, "R5", "remote held in Pause-IR", lst, S_PI);
        default: begin
          if (kind == 0 && age >= 1) chk(lst == S_RTI, "R6", "remote idle during wake", lst, S_RTI);
          if (kind == 1) chk(lst == S_PD, "R7", "remote Pause-DR during wake", lst, S_PD);
          if (kind == 2) chk(lst == S_PI, "R7", "remote Pause-IR during wake", lst, S_PI);
        end
      endcase
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops;
    trst_n = 1'b0; bridge_state = S_TLR; tmsb = 1'b1;
    op_wake = 0; op_park_reset = 0; op_park_idle = 0; op_park_pause = 0;
    mode = M_TLR; kind = 0; age = 0; lst = S_HD;
    for (int i = 0; i < 6; i++) tick(1'b1, 4'b0000, 1'b0);
    // R1: reset state
    chk(tmsl == 1'b1, "R1", "tmsl in reset", tmsl, 1);
    chk(in_chain == 1'b0, "R1", "in_chain in reset", in_chain, 0);
    chk(lst == S_TLR, "R1", "remote walked to reset", lst, S_TLR);
    trst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0, 4'b0000, 1'b1);
    chk(in_chain == 1'b0, "R1", "still parked after reset release", in_chain, 0);
    // sweep
    for (int i = 0; i < 60000; i++) begin
      rng = xs(rng);
      ops = 4'b0000;
      if (bridge_state == S_UI) begin
        case (rng[10:8])
          3'd0, 3'd1, 3'd2: ops = 4'b0001;
          3'd3:             ops = 4'b0010;
          3'd4:             ops = 4'b0100;
          3'd5, 3'd6:       ops = 4'b1000;
          default:          ops = 4'b0000;
        endcase
      end
      tick(rng[0] & (rng[3] | rng[5]) | (rng[1] & rng[2]), ops, 1'b1);
    end
    chk(n_pause_park > 0, "R5", "pause parks seen", n_pause_park, 1);
    chk(n_idle_wake > 0, "R6", "idle wakes seen", n_idle_wake, 1);
    chk(n_pause_wake > 0, "R7", "pause wakes seen", n_pause_wake, 1);
    chk(n_cancel + n_ignored > 0, "R8", "ignored or cancelled strobes seen", n_cancel + n_ignored, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule